// File: doc/BRIEF.md
# Predicated Vector-Span Add Sequencer

This block is a hardware loop that expands one scalar integer add into a run of element adds over consecutive registers of an ordinary integer register file. Each of the three operands (destination and two sources) carries a tag. A tagged operand steps one register per element. An untagged operand stays on its base register and acts as a scalar. One sequencer therefore covers scalar-scalar, scalar-vector and vector-vector adds.

The register file lives outside the block and is reached through two combinational read ports for the sources, one read port for the mask register and one write port. The mask is a plain integer register whose bit i enables element i. It is read once, when the operation is accepted. Elements run one per cycle, in order, and each element sees the writes of the earlier ones. The caller raises `start` for one cycle and waits for the single-cycle `done` pulse.

Top module: `vspan_add_seq`

## Requirements
- R1: An accepted operation runs N = min(vl, dst_span, XLEN) elements, one per clock cycle, with `busy` high for exactly those N cycles. The element index advances every cycle, whether or not the element is masked.
- R2: `done` is a one-cycle pulse in the cycle after the last element. When N is zero, `done` pulses in the cycle after `start` and no write occurs. After reset, `busy`, `done` and `rf_we` are low.
- R3: Element i is written only when bit i of the mask register is set. The mask register is named by `pred_sel` and sampled when `start` is accepted. A masked element uses its cycle with `rf_we` low.
- R4: For element i, an operand tagged vectorised uses register (base + i) mod 32. An untagged operand uses its base register for every element.
- R5: Element i writes the sum of its two source registers, modulo 2^XLEN.
- R6: Register 0 reads as zero, both as a source and as the mask register. Register 0 is never written: `rf_we` stays low whenever the destination register number is 0.
- R7: A `start` pulse while `busy` is high is ignored. The running operation completes with its original operands and timing.
- R8: Elements execute in order, so a source register written by an earlier element of the same operation supplies its new value. This includes a scalar destination that is also a source, which accumulates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| rd_sel | input | 5 | Destination base register |
| rs1_sel | input | 5 | First source base register |
| rs2_sel | input | 5 | Second source base register |
| pred_sel | input | 5 | Register holding the element mask |
| rd_vec | input | 1 | Destination steps per element |
| rs1_vec | input | 1 | First source steps per element |
| rs2_vec | input | 1 | Second source steps per element |
| vl | input | 6 | Global vector length |
| dst_span | input | 6 | Span length configured for the destination |
| busy | output | 1 | Elements are being processed |
| done | output | 1 | One-cycle completion pulse |
| rf_ra1 | output | 5 | Read address, first source |
| rf_rd1 | input | 32 | Read data, first source |
| rf_ra2 | output | 5 | Read address, second source |
| rf_rd2 | input | 32 | Read data, second source |
| rf_rap | output | 5 | Read address, mask register |
| rf_rdp | input | 32 | Read data, mask register |
| rf_we | output | 1 | Register write enable |
| rf_wa | output | 5 | Register write address |
| rf_wd | output | 32 | Register write data |

## Verification
Directed operations try each tag combination: all vectorised, a scalar source against vector operands, and a scalar destination that is also a source. These separate per-operand stepping from stepping that is shared by all operands, and show whether accumulation uses the freshly written value. Alternating masks, an all-zero mask and the register-0 mask separate masked cycles from skipped cycles and from missing writes. Spans that cross register 31 into 0 exercise address wrapping and the register-0 rules. Lengths of zero, lengths where the span is below the vector length, and lengths above the register width fix the element count. An overflowing sum and a start pulse sent mid-run cover wrap-around and the ignored start. Random operations with overlapping spans then compare the whole register file, the write count and the latency against a sequential model in the bench.

// File: rtl/vspan_pkg.sv
package vspan_pkg;

  // Number of elements: smallest of vector length, destination span and cap.
  function automatic int span_count(int vl_n, int span_n, int cap);
    int m;
    m = (vl_n < span_n) ? vl_n : span_n;
    return (m < cap) ? m : cap;
  endfunction

  // Register number of element offset off from base, wrapping in the file.
  function automatic int elem_reg(int base, int off, int nreg);
    return (base + off) % nreg;
  endfunction

endpackage

// File: rtl/vspan_ctrl.sv
module vspan_ctrl #(
  parameter int XLEN = 32,
  parameter int VLW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic [VLW-1:0] span,
  output logic           busy,
  output logic           done,
  output logic           accept,
  output logic           last,
  output logic [VLW-1:0] idx
);
  logic [VLW-1:0] cnt_q;
  logic [VLW-1:0] cnt_d;

  assign cnt_d  = VLW'(vspan_pkg::span_count(int'(vl), int'(span), XLEN));
  assign accept = start && !busy;
  assign last   = busy && (idx == cnt_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cnt_q <= cnt_d;
        idx   <= '0;
        if (cnt_d == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vspan_elem_addr.sv
module vspan_elem_addr #(
  parameter int AW   = 5,
  parameter int VLW  = 6
) (
  input  logic [AW-1:0]  base,
  input  logic           vec,
  input  logic [VLW-1:0] idx,
  output logic [AW-1:0]  addr
);
  localparam int NREG = 1 << AW;

  assign addr = AW'(vspan_pkg::elem_reg(int'(base), vec ? int'(idx) : 0, NREG));
endmodule

// File: rtl/vspan_dp.sv
module vspan_dp #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int VLW  = 6
) (
  input  logic            busy,
  input  logic [VLW-1:0]  idx,
  input  logic [XLEN-1:0] mask,
  input  logic [AW-1:0]   addr_d,
  input  logic [AW-1:0]   addr_a,
  input  logic [AW-1:0]   addr_b,
  input  logic [XLEN-1:0] data_a,
  input  logic [XLEN-1:0] data_b,
  output logic            elem_en,
  output logic            we,
  output logic [AW-1:0]   wa,
  output logic [XLEN-1:0] wd
);
  localparam int IW = $clog2(XLEN);

  function automatic logic [XLEN-1:0] src_val(logic [AW-1:0] a, logic [XLEN-1:0] d);
    return (a == '0) ? '0 : d;
  endfunction

  function automatic logic [XLEN-1:0] add_wrap(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    return x + y;
  endfunction

  assign elem_en = mask[idx[IW-1:0]];
  assign we      = busy && elem_en && (addr_d != '0);
  assign wa      = addr_d;
  assign wd      = add_wrap(src_val(addr_a, data_a), src_val(addr_b, data_b));
endmodule

// File: rtl/vspan_add_seq.sv
module vspan_add_seq #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int VLW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   rd_sel,
  input  logic [AW-1:0]   rs1_sel,
  input  logic [AW-1:0]   rs2_sel,
  input  logic [AW-1:0]   pred_sel,
  input  logic            rd_vec,
  input  logic            rs1_vec,
  input  logic            rs2_vec,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  dst_span,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   rf_ra1,
  input  logic [XLEN-1:0] rf_rd1,
  output logic [AW-1:0]   rf_ra2,
  input  logic [XLEN-1:0] rf_rd2,
  output logic [AW-1:0]   rf_rap,
  input  logic [XLEN-1:0] rf_rdp,
  output logic            rf_we,
  output logic [AW-1:0]   rf_wa,
  output logic [XLEN-1:0] rf_wd
);
  localparam int NOPS = 3;  // 0: destination, 1: first source, 2: second source

  logic                       accept;
  logic                       last_elem;
  logic                       elem_en;
  logic [VLW-1:0]             idx;
  logic [XLEN-1:0]            mask_q;
  logic [NOPS-1:0]            vec_q;
  logic [NOPS-1:0][AW-1:0]    base_q;
  logic [NOPS-1:0][AW-1:0]    op_addr;

  vspan_ctrl #(.XLEN(XLEN), .VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .span(dst_span),
    .busy(busy), .done(done), .accept(accept), .last(last_elem), .idx(idx)
  );

  assign rf_rap = pred_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      vec_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      mask_q    <= (pred_sel == '0) ? '0 : rf_rdp;
      vec_q     <= {rs2_vec, rs1_vec, rd_vec};
      base_q[0] <= rd_sel;
      base_q[1] <= rs1_sel;
      base_q[2] <= rs2_sel;
    end
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_addr
    vspan_elem_addr #(.AW(AW), .VLW(VLW)) u_addr (
      .base(base_q[g]), .vec(vec_q[g]), .idx(idx), .addr(op_addr[g])
    );
  end

  assign rf_ra1 = op_addr[1];
  assign rf_ra2 = op_addr[2];

  vspan_dp #(.XLEN(XLEN), .AW(AW), .VLW(VLW)) u_dp (
    .busy(busy), .idx(idx), .mask(mask_q),
    .addr_d(op_addr[0]), .addr_a(op_addr[1]), .addr_b(op_addr[2]),
    .data_a(rf_rd1), .data_b(rf_rd2),
    .elem_en(elem_en), .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );
endmodule

// File: rtl/vspan_add_seq_chk.sv
module vspan_add_seq_chk #(
  parameter int AW  = 5,
  parameter int VLW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           rf_we,
  input logic [AW-1:0]  rf_wa,
  input logic [2:0]     vec_q,
  input logic [VLW-1:0] idx
);
  a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wa != '0));

  a_r3_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx == VLW'($past(idx) + 1'b1)));

  a_r4_scalar_dest_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !vec_q[0]) |-> $stable(rf_wa));

  a_r4_vector_dest_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && vec_q[0]) |-> (rf_wa == AW'($past(rf_wa) + 1'b1)));
endmodule

bind vspan_add_seq vspan_add_seq_chk #(.AW(AW), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rf_we(rf_we), .rf_wa(rf_wa), .vec_q(vec_q), .idx(idx)
);

// File: tb/sim_vspan_add_seq.sv
module sim_vspan_add_seq;
  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam int VLW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] rd_sel = '0, rs1_sel = '0, rs2_sel = '0, pred_sel = '0;
  logic rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
  logic [VLW-1:0] vl = '0, dst_span = '0;
  logic busy, done, rf_we;
  logic [AW-1:0] rf_ra1, rf_ra2, rf_rap, rf_wa;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_rdp, rf_wd;

  logic [XLEN-1:0] rf [32];
  logic [XLEN-1:0] expv [32];
  int n_checks = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int zero_wr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vspan_add_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_sel(rd_sel), .rs1_sel(rs1_sel), .rs2_sel(rs2_sel), .pred_sel(pred_sel),
    .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
    .vl(vl), .dst_span(dst_span), .busy(busy), .done(done),
    .rf_ra1(rf_ra1), .rf_rd1(rf_rd1), .rf_ra2(rf_ra2), .rf_rd2(rf_rd2),
    .rf_rap(rf_rap), .rf_rdp(rf_rdp),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd)
  );

  assign rf_rd1 = rf[rf_ra1];
  assign rf_rd2 = rf[rf_ra2];
  assign rf_rdp = rf[rf_rap];

  always @(posedge clk) begin
    if (rf_we) begin
      rf[rf_wa] <= rf_wd;
      wr_cnt <= wr_cnt + 1;
      if (rf_wa == '0) zero_wr <= zero_wr + 1;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int min3(int a, int b, int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic logic [XLEN-1:0] rdz(int r);
    return (r == 0) ? '0 : expv[r];
  endfunction

  // Sequential reference: returns expected number of writes, updates expv.
  function automatic int model(int d, int a, int b, int p, bit vd, bit va, bit vb,
                               int vlen, int span);
    int n, w;
    logic [XLEN-1:0] m;
    n = min3(vlen, span, XLEN);
    m = rdz(p);
    w = 0;
    for (int i = 0; i < n; i++) begin
      int rd_n, ra_n, rb_n;
      rd_n = (d + (vd ? i : 0)) % 32;
      ra_n = (a + (va ? i : 0)) % 32;
      rb_n = (b + (vb ? i : 0)) % 32;
      if (m[i] && rd_n != 0) begin
        expv[rd_n] = rdz(ra_n) + rdz(rb_n);
        w++;
      end
    end
    return w;
  endfunction

  task automatic run_op(int d, int a, int b, int p, bit vd, bit va, bit vb,
                        int vlen, int span, string req, bit poke);
    int n, k, w0, wexp, bad;
    for (int r = 0; r < 32; r++) expv[r] = rf[r];
    wexp = model(d, a, b, p, vd, va, vb, vlen, span);
    n = min3(vlen, span, XLEN);
    @(negedge clk);
    rd_sel = AW'(d); rs1_sel = AW'(a); rs2_sel = AW'(b); pred_sel = AW'(p);
    rd_vec = vd; rs1_vec = va; rs2_vec = vb;
    vl = VLW'(vlen); dst_span = VLW'(span);
    w0 = wr_cnt;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 100) begin
      if (poke && k == 1) begin
        // R7: different operands and a start pulse while running
        start = 1'b1; rd_sel = AW'(d + 7); rs1_sel = AW'(b); rs2_sel = AW'(a);
        pred_sel = '0; vl = '0; dst_span = '0; rd_vec = ~vd;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == n, req, "cycles start to done (R1/R2)", k, n);
    @(negedge clk);
    check(!busy && !done, req, "idle after done pulse (R2)", {busy, done}, 0);
    check(wr_cnt - w0 == wexp, req, "write count (R3)", wr_cnt - w0, wexp);
    bad = -1;
    for (int r = 1; r < 32; r++) if (bad < 0 && rf[r] !== expv[r]) bad = r;
    if (bad < 0) check(1'b1, req, "register file", 0, 0);
    else check(1'b0, req, $sformatf("register x%0d", bad), rf[bad], expv[bad]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < 32; r++) rf[r] = XLEN'(r * 32'h0101_0011 + 5);
    rf[0] = 32'hDEAD_BEEF;  // R6: block must never see this value
    repeat (3) @(negedge clk);
    check(!busy && !done && !rf_we, "R2", "reset outputs", {busy, done, rf_we}, 0);
    rst_n = 1'b1;

    // R4 R5: vector-vector, full mask
    rf[20] = 32'hFFFF_FFFF;
    run_op(1, 10, 14, 20, 1, 1, 1, 4, 8, "R4", 0);
    // R4: scalar second source against vector first source
    run_op(5, 12, 3, 20, 1, 1, 0, 5, 5, "R4", 0);
    // R8: scalar destination is also scalar source, accumulates
    rf[7] = 32'd3; rf[8] = 32'd10;
    run_op(7, 7, 8, 20, 0, 0, 0, 6, 6, "R8", 0);
    check(rf[7] == 32'd63, "R8", "accumulated value", rf[7], 63);
    // R3: alternating mask
    rf[21] = 32'h5555_5555;
    run_op(24, 2, 9, 21, 1, 1, 1, 6, 6, "R3", 0);
    // R3: all-zero mask, every element a cycle without write
    rf[22] = 32'h0;
    run_op(24, 2, 9, 22, 1, 1, 1, 7, 7, "R3", 0);
    // R6: mask register 0 reads zero
    run_op(24, 2, 9, 0, 1, 1, 1, 5, 5, "R6", 0);
    // R2: zero length and zero span
    run_op(3, 4, 5, 20, 1, 1, 1, 0, 9, "R2", 0);
    run_op(3, 4, 5, 20, 1, 1, 1, 9, 0, "R2", 0);
    // R1: span below vector length, and length above register width
    run_op(11, 4, 5, 20, 1, 1, 1, 9, 3, "R1", 0);
    rf[23] = 32'hFFFF_FFFF;
    run_op(2, 2, 2, 23, 1, 0, 1, 40, 45, "R1", 0);
    // R4 R6: spans wrapping past register 31 through register 0
    rf[20] = 32'hFFFF_FFFF;
    run_op(30, 29, 31, 20, 1, 1, 1, 4, 4, "R6", 0);
    check(zero_wr == 0, "R6", "writes to register 0", zero_wr, 0);
    // R5: overflow wraps
    rf[12] = 32'hFFFF_FFFF; rf[13] = 32'h0000_0002;
    run_op(14, 12, 13, 20, 0, 0, 0, 1, 1, "R5", 0);
    check(rf[14] == 32'h1, "R5", "wrapped sum", rf[14], 1);
    // R7: start while busy is ignored
    run_op(16, 1, 2, 20, 1, 1, 1, 6, 6, "R7", 1);

    // random operations with overlapping spans
    for (int t = 0; t < 40; t++) begin
      int d, a, b, p;
      d = int'($urandom_range(31)); a = int'($urandom_range(31));
      b = int'($urandom_range(31)); p = int'($urandom_range(31));
      for (int r = 1; r < 32; r++)
        if ($urandom_range(3) == 0) rf[r] = $urandom();
      run_op(d, a, b, p, 1'($urandom_range(1)), 1'($urandom_range(1)),
             1'($urandom_range(1)), int'($urandom_range(35)),
             int'($urandom_range(35)), "R4", 0);
    end
    check(zero_wr == 0, "R6", "writes to register 0 overall", zero_wr, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule